// File: doc/BRIEF.md
# Quad DAC Serial Load Controller

This block sits on the host side of a four-channel 12-bit serial DAC and turns each accepted request into one complete update of a single channel. A request names a channel (two bits) and a 12-bit output code. The controller packs these into a 16-bit word and shifts it out as two back-to-back bytes, most significant bit first, within one chip-select window. The serial clock idles high, and the DAC samples data on each rising edge. When the second byte is done, chip select is released while the clock is high. After a short setup gap, a separate active-low load strobe moves the shifted word into the DAC output register.

Requests arrive on a valid/ready handshake. Ready is high only while the controller is idle, so back-pressure covers the whole frame, including the load strobe. A request is taken on a clock edge where both valid and ready are high. The requester must hold its channel and code stable while valid is high and ready is low. A separate clear input goes straight through, inverted, to the DAC's asynchronous clear pin. The same input also aborts any frame in progress and returns the controller to idle.

Top module: `qdac_loader`

## Requirements
- R1: When no frame is in progress, `dac_sclk` is high. During a frame, `dac_sdi` changes only together with a falling edge of `dac_sclk`, so it is stable at every rising edge.
- R2: Each frame has exactly 16 rising edges of `dac_sclk` while `dac_cs_n` is low, with bits shifted out most significant first.
- R3: Word bits 15:14 carry the channel (0=A, 1=B, 2=C, 3=D), bits 13:12 are 0, and bits 11:0 carry the code.
- R4: `dac_cs_n` falls on the clock edge that accepts a request. It then stays low, with `dac_sclk` high, for HALF_DIV system clocks before the first falling edge. It stays low until all 16 bits have been sent.
- R5: `dac_cs_n` rises only while `dac_sclk` is high, HALF_DIV clocks after the last rising edge. `dac_sclk` has no edge while `dac_cs_n` is high.
- R6: After `dac_cs_n` rises, `dac_load_n` stays high for LOAD_SETUP system clocks (at least 1). It then goes low for exactly LOAD_CYCLES system clocks, and only while `dac_cs_n` is high.
- R7: `dac_load_n` is high again before `dac_cs_n` falls for the next frame, including when requests arrive back to back.
- R8: `req_ready` is high only when idle and `clear_in` is low. A request is accepted only when `req_valid` and `req_ready` are both high. Ready stays low from acceptance until the load strobe ends.
- R9: `dac_clr_n` is the combinational inverse of `clear_in`. A high `clear_in` returns the controller to idle on the next clock, with `dac_cs_n`, `dac_load_n` and `dac_sclk` high, and no load strobe is issued for the aborted frame.
- R10: Each low phase and each high phase of `dac_sclk` within a frame lasts HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_in | input | 1 | Clear request: clears the DAC and aborts any frame |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_chan | input | 2 | Channel select, 0..3 for A..D |
| req_code | input | 12 | Output code for the channel |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdi | output | 1 | Serial data, stable at rising clock edges |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_load_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Asynchronous DAC clear, active low |

## Verification
A wrong state in the sequencer or the shift counter shows up within one frame as a wrong number of rising clock edges, or as a word whose channel or code bits are shifted or swapped. A wrong timer shows up as a phase, lead, gap or strobe width different from its parameter, measured in system clocks. Chip select released while the clock is low, or a load strobe that overlaps chip select, would give the DAC an extra shift or a torn word. Both appear at the pins on the very clock where the state goes wrong. A clear that fails to take effect leaves chip select low, or lets a load strobe through, within a few clocks of the clear.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  localparam int ADDR_W  = 2;
  localparam int CODE_W  = 12;
  localparam int FRAME_W = 16;
  localparam int PAD_W   = FRAME_W - ADDR_W - CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_PULSE
  } qdac_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [ADDR_W-1:0] ch,
    input logic [CODE_W-1:0] code
  );
    return {ch, {PAD_W{1'b0}}, code};
  endfunction

endpackage

// File: rtl/qdac_span_timer.sv
module qdac_span_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic [W-1:0] len_m1,
  output logic         expired
);

  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (reload) begin
      remain <= len_m1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

  // the count only moves down between reloads
  assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(remain) != '0 && !$past(reload)) |-> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/qdac_frame_shifter.sv
module qdac_frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               advance,
  output logic               msb,
  output logic               last
);

  localparam int CW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [CW-1:0]      bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (load) begin
      shreg  <= frame;
      bitcnt <= '0;
    end else if (advance) begin
      shreg  <= {shreg[FRAME_W-2:0], 1'b0};
      bitcnt <= bitcnt + 1'b1;
    end
  end

  assign msb  = shreg[FRAME_W-1];
  assign last = (bitcnt == CW'(FRAME_W - 1));

  assert_no_load_and_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && advance));

  assert_no_shift_past_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !last);

endmodule

// File: rtl/qdac_loader.sv
module qdac_loader
  import qdac_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int LOAD_CYCLES = 2,
  parameter int LOAD_SETUP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_cs_n,
  output logic              dac_load_n,
  output logic              dac_clr_n
);

  localparam int           MAXLEN = max3(HALF_DIV, LOAD_CYCLES, LOAD_SETUP);
  localparam int           TW     = $clog2(MAXLEN + 1);
  localparam logic [TW-1:0] HALF_M1  = TW'(HALF_DIV - 1);
  localparam logic [TW-1:0] SETUP_M1 = TW'(LOAD_SETUP - 1);
  localparam logic [TW-1:0] PULSE_M1 = TW'(LOAD_CYCLES - 1);

  qdac_state_e   state, state_nxt;
  logic          t_reload, t_expired;
  logic [TW-1:0] t_len;
  logic          s_load, s_advance, s_msb, s_last;
  logic          accept;

  assign req_ready = (state == ST_IDLE) && !clear_in;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nxt = state;
    t_reload  = 1'b0;
    t_len     = HALF_M1;
    s_load    = 1'b0;
    s_advance = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        state_nxt = ST_LEAD;
        t_reload  = 1'b1;
        s_load    = 1'b1;
      end
      ST_LEAD: if (t_expired) begin
        state_nxt = ST_LOW;
        t_reload  = 1'b1;
      end
      ST_LOW: if (t_expired) begin
        state_nxt = ST_HIGH;
        t_reload  = 1'b1;
      end
      ST_HIGH: if (t_expired) begin
        t_reload = 1'b1;
        if (s_last) begin
          state_nxt = ST_GAP;
          t_len     = SETUP_M1;
        end else begin
          state_nxt = ST_LOW;
          s_advance = 1'b1;
        end
      end
      ST_GAP: if (t_expired) begin
        state_nxt = ST_PULSE;
        t_reload  = 1'b1;
        t_len     = PULSE_M1;
      end
      ST_PULSE: if (t_expired) begin
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
    if (clear_in) begin
      state_nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nxt;
    end
  end

  qdac_span_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (t_reload),
    .len_m1  (t_len),
    .expired (t_expired)
  );

  qdac_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (s_load),
    .frame   (pack_frame(req_chan, req_code)),
    .advance (s_advance),
    .msb     (s_msb),
    .last    (s_last)
  );

  assign dac_sclk   = (state != ST_LOW);
  assign dac_cs_n   = !((state == ST_LEAD) || (state == ST_LOW) || (state == ST_HIGH));
  assign dac_load_n = (state != ST_PULSE);
  assign dac_sdi    = s_msb;
  assign dac_clr_n  = !clear_in;

  assert_sdi_stable_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk) && !dac_cs_n && !$past(dac_cs_n)) |-> $stable(dac_sdi));

  assert_sclk_low_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_sclk |-> !dac_cs_n);

  assert_cs_release_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dac_cs_n) && !$past(clear_in)) |-> (dac_sclk && $past(dac_sclk)));

  assert_load_outside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load_n |-> dac_cs_n);

  assert_load_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_load_n) |-> $past(dac_cs_n));

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dac_cs_n && dac_load_n && dac_sclk));

  assert_clear_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_in |=> (dac_cs_n && dac_load_n && dac_sclk));

endmodule

// File: tb/qdac_loader_bench.sv
module qdac_loader_bench;

  localparam int HALF_DIV    = 4;
  localparam int LOAD_CYCLES = 2;
  localparam int LOAD_SETUP  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_in = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = '0;
  logic [11:0] req_code = '0;
  logic        dac_sclk, dac_sdi, dac_cs_n, dac_load_n, dac_clr_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  qdac_loader #(
    .HALF_DIV(HALF_DIV), .LOAD_CYCLES(LOAD_CYCLES), .LOAD_SETUP(LOAD_SETUP)
  ) u_qdac_loader (
    .clk(clk), .rst_n(rst_n), .clear_in(clear_in),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code),
    .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_cs_n(dac_cs_n),
    .dac_load_n(dac_load_n), .dac_clr_n(dac_clr_n)
  );

  // port monitor, sampled on the falling system clock edge
  logic        prev_sclk = 1'b1, prev_cs = 1'b1, prev_load = 1'b1;
  logic [15:0] cap = '0, last_word = '0;
  int frames = 0, loads = 0, edges = 0, last_edges = 0, stray = 0, r7_bad = 0;
  int lo_run = 0, lo_min = 0, lo_max = 0, hi_run = 0, hi_min = 0, hi_max = 0;
  int lead = 0, seen_low = 0, gap = 0, gapping = 0, last_gap = 0, lw = 0, last_lw = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dac_cs_n && prev_cs) begin
        frames++;
        if (!dac_load_n) r7_bad++;
        cap = '0; edges = 0; lo_run = 0; hi_run = 0; lead = 0; seen_low = 0;
        lo_min = 1000; lo_max = 0; hi_min = 1000; hi_max = 0; gapping = 0;
      end
      if (!dac_cs_n && dac_sclk && seen_low == 0) lead++;
      if (!dac_sclk && prev_sclk && !dac_cs_n && seen_low != 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
      end
      if (!dac_sclk) begin
        lo_run++; seen_low = 1; hi_run = 0;
        if (dac_cs_n) stray++;
      end else begin
        hi_run++;
      end
      if (dac_sclk && !prev_sclk) begin
        if (!dac_cs_n) begin
          cap = {cap[14:0], dac_sdi};
          edges++;
          if (lo_run < lo_min) lo_min = lo_run;
          if (lo_run > lo_max) lo_max = lo_run;
          hi_run = 1;
        end else begin
          stray++;
        end
        lo_run = 0;
      end
      if (dac_cs_n && !prev_cs) begin
        gap = 1; gapping = 1;
      end else if (gapping != 0 && dac_cs_n && dac_load_n) begin
        gap++;
      end
      if (!dac_load_n && prev_load) begin
        last_gap = gap; gapping = 0; lw = 0;
      end
      if (!dac_load_n) lw++;
      if (dac_load_n && !prev_load) begin
        last_lw = lw; last_word = cap; last_edges = edges; loads++;
      end
    end
    prev_sclk = dac_sclk;
    prev_cs   = dac_cs_n;
    prev_load = dac_load_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] ch, input logic [11:0] code);
    @(negedge clk);
    req_chan = ch; req_code = code; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_loads(input int target);
    int n = 0;
    while (loads < target && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(dac_sclk == 1'b1,   "R1 sclk idle", dac_sclk, 1);
    chk(dac_cs_n == 1'b1,   "R4 cs idle", dac_cs_n, 1);
    chk(dac_load_n == 1'b1, "R6 load idle", dac_load_n, 1);
    chk(req_ready == 1'b1,  "R8 ready idle", req_ready, 1);
    chk(dac_clr_n == 1'b1,  "R9 clr idle", dac_clr_n, 1);
    repeat (20) @(negedge clk);
    chk(frames == 0, "R8 no frame without valid", frames, 0);
  endtask

  task automatic t_frame(input logic [1:0] ch, input logic [11:0] code);
    int l0 = loads;
    logic [15:0] exp_w = {ch, 2'b00, code};
    stray = 0;
    send(ch, code);
    chk(req_ready == 1'b0, "R8 ready low when busy", req_ready, 0);
    wait_loads(l0 + 1);
    chk(last_word == exp_w, "R3 word layout", last_word, exp_w);
    chk(last_edges == 16, "R2 rising edge count", last_edges, 16);
    chk(lead == HALF_DIV, "R4 lead before first fall", lead, HALF_DIV);
    chk(lo_min == HALF_DIV && lo_max == HALF_DIV, "R10 low phase", lo_max, HALF_DIV);
    chk(hi_min == HALF_DIV && hi_max == HALF_DIV, "R10 high phase", hi_max, HALF_DIV);
    chk(last_gap == LOAD_SETUP, "R6 setup gap", last_gap, LOAD_SETUP);
    chk(last_lw == LOAD_CYCLES, "R6 load width", last_lw, LOAD_CYCLES);
    chk(stray == 0, "R5 no sclk edge outside cs", stray, 0);
    chk(dac_sclk == 1'b1, "R1 sclk idle after frame", dac_sclk, 1);
  endtask

  task automatic t_back_to_back;
    int l0 = loads;
    r7_bad = 0;
    send(2'd2, 12'h5A5);
    send(2'd1, 12'h0F0);
    wait_loads(l0 + 2);
    chk(last_word == 16'h80F0 - 16'h4000 + 16'h0000, "R3 second word", last_word, 16'h40F0);
    chk(r7_bad == 0, "R7 load high before next cs fall", r7_bad, 0);
    chk(loads == l0 + 2, "R8 one frame per handshake", loads - l0, 2);
  endtask

  task automatic t_clear;
    int l0 = loads;
    send(2'd3, 12'h777);
    repeat (40) @(negedge clk);
    chk(dac_cs_n == 1'b0, "R4 cs low mid frame", dac_cs_n, 0);
    clear_in = 1'b1;
    #1;
    chk(dac_clr_n == 1'b0, "R9 clr follows clear_in", dac_clr_n, 0);
    chk(req_ready == 1'b0, "R8 ready low under clear", req_ready, 0);
    @(negedge clk);
    chk(dac_cs_n == 1'b1 && dac_load_n == 1'b1 && dac_sclk == 1'b1,
        "R9 idle after clear", {dac_cs_n, dac_load_n, dac_sclk}, 3'b111);
    repeat (3) @(negedge clk);
    clear_in = 1'b0;
    #1;
    chk(dac_clr_n == 1'b1, "R9 clr released", dac_clr_n, 1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready after clear", req_ready, 1);
    repeat (200) @(negedge clk);
    chk(loads == l0, "R9 no load for aborted frame", loads, l0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame(2'd0, 12'h000);
    t_frame(2'd1, 12'hFFF);
    t_frame(2'd2, 12'hA5A);
    t_frame(2'd3, 12'h123);
    t_back_to_back();
    t_clear();
    t_frame(2'd3, 12'hC3C);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule